// File: doc/BRIEF.md
# Parallel Add/Multiply/Logic Unit with Range-Decoded Select

This block is a purely combinational arithmetic and logic unit for two unsigned 4-bit operands. An adder, a multiplier and three bitwise gates all evaluate the operands at the same time. A 4-bit select word then picks one of those results and places it on an 8-bit output. No result is held in a register; the output follows its inputs within the same clock cycle.

The multiplier uses the vertical-and-crosswise method. Each operand is split into halves. Four half-width partial products are formed independently. The two cross terms are added first, and that sum is then added, shifted, onto the concatenated outer products. The construction recurses down to a 2x2 cell, so the operand width parameter must be a power of two of at least 2.

The select word is decoded as ranges of codes rather than one code per operation. The lowest four codes choose the sum. The nine middle codes choose the product. The top three codes each choose one logic operation.

Top module: `alu_vc_mux`

## Requirements
- R1: The select word is an unsigned number with sel[3] as its most significant bit. For codes 0 to 3, result equals the 5-bit sum opnd_a + opnd_b, zero-extended to 8 bits.
- R2: For codes 4 to 12 inclusive, result equals the full 8-bit unsigned product opnd_a * opnd_b.
- R3: For code 13, result[3:0] equals opnd_a AND opnd_b bitwise, and result[7:4] is zero.
- R4: For code 14, result[3:0] equals opnd_a OR opnd_b bitwise, and result[7:4] is zero.
- R5: For code 15, result[3:0] equals the bitwise inverse of opnd_a and result[7:4] is zero. opnd_b has no effect on result.
- R6: The block holds no state. After any change of operands or select, result settles to the new value in the same cycle, with no clock edge needed.
- R7: The corner values are exact: 15 + 15 gives 30 (0x1E) and 15 * 15 gives 225 (0xE1). The multiplier's final carry never leaves the 8-bit product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 4 | First unsigned operand; the only input to the inversion |
| opnd_b | input | 4 | Second unsigned operand |
| sel | input | 4 | Operation select code, sel[3] most significant |
| result | output | 8 | Selected result, zero-extended where it is narrower |

## Verification
Every result is due zero cycles after its stimulus, because the adder, the multiplier, the gates and the select path are all combinational. The bench changes the operands and the select at the falling clock edge and samples result 2 ns later, well before the next rising edge. A new stimulus is never applied before the previous sample has been taken. The R6 test keeps the operands fixed and changes only the select within one low clock phase, so a result that waited for a clock edge would be caught.

// File: rtl/alu_vc_pkg.sv
// Package alu_vc_pkg
// Holds the shared operand width, the select-range boundaries, the class
// of operation for each code, and the decode function from code to class.
// Assumes a 4-bit select word read as an unsigned number.
package alu_vc_pkg;

    localparam int OPND_W = 4;
    localparam int SEL_W  = 4;
    localparam int RES_W  = 2 * OPND_W;

    // Range boundaries; the order of the ranges is behaviour.
    localparam logic [SEL_W-1:0] ADD_LAST = 4'd3;
    localparam logic [SEL_W-1:0] MUL_LAST = 4'd12;
    localparam logic [SEL_W-1:0] AND_CODE = 4'd13;
    localparam logic [SEL_W-1:0] OR_CODE  = 4'd14;

    typedef enum logic [2:0] {
        CLS_SUM  = 3'd0,
        CLS_PROD = 3'd1,
        CLS_AND  = 3'd2,
        CLS_OR   = 3'd3,
        CLS_INV  = 3'd4
    } op_class_e;

    // Maps one select code to the class of operation it picks.
    function automatic op_class_e decode_sel(input logic [SEL_W-1:0] code);
        if (code <= ADD_LAST)      return CLS_SUM;
        else if (code <= MUL_LAST) return CLS_PROD;
        else if (code == AND_CODE) return CLS_AND;
        else if (code == OR_CODE)  return CLS_OR;
        else                       return CLS_INV;
    endfunction

endpackage

// File: rtl/rca_add.sv
// Module rca_add
// Ripple-carry adder of N bits built from a chain of full-adder cells.
// Assumes N >= 1. Gives an N-bit sum and the carry out of the top cell.
module rca_add #(
    parameter int N = 4
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);

    logic [N:0] carry;

    // Feeds the incoming carry into the bottom of the chain.
    assign carry[0] = cin;

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            // One full-adder cell: sum bit and its carry to the next cell.
            always_comb begin
                sum[i]     = x[i] ^ y[i] ^ carry[i];
                carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
            end
        end
    endgenerate

    // Brings out the carry of the top cell.
    assign cout = carry[N];

endmodule

// File: rtl/vc_mul.sv
// Module vc_mul
// Unsigned W x W multiplier built the vertical-and-crosswise way.
// Each operand is split into halves. The four half products are formed in
// parallel, the two cross products are added, and that sum is then added,
// shifted by one half, onto {high*high, low*low}. The build recurses to a
// 2x2 cell. Assumes W is a power of two of at least 2. spill is the carry
// out of the last adder and stays zero because a product fits in 2W bits.
module vc_mul #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    logic spill;

    generate
        if (W == 2) begin : g_base
            logic cross_k;

            // 2x2 cell: vertical bit 0, crosswise bit 1, then the top pair.
            always_comb begin
                p[0]    = a[0] & b[0];
                p[1]    = (a[1] & b[0]) ^ (a[0] & b[1]);
                cross_k = (a[1] & b[0]) & (a[0] & b[1]);
                p[2]    = (a[1] & b[1]) ^ cross_k;
                p[3]    = (a[1] & b[1]) & cross_k;
                spill   = 1'b0;
            end
        end else begin : g_split
            localparam int H   = W / 2;
            localparam int PAD = 2 * W - (W + 1) - H;

            logic [W-1:0]   pp_ll;
            logic [W-1:0]   pp_lh;
            logic [W-1:0]   pp_hl;
            logic [W-1:0]   pp_hh;
            logic [W-1:0]   cross_sum;
            logic           cross_co;
            logic [2*W-1:0] outer;
            logic [2*W-1:0] cross_sh;

            vc_mul #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(pp_ll));
            vc_mul #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(pp_lh));
            vc_mul #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(pp_hl));
            vc_mul #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(pp_hh));

            rca_add #(.N(W)) u_cross (
                .x(pp_lh), .y(pp_hl), .cin(1'b0),
                .sum(cross_sum), .cout(cross_co)
            );

            // Lines up the outer products and the shifted cross sum.
            always_comb begin
                outer    = {pp_hh, pp_ll};
                cross_sh = {{PAD{1'b0}}, cross_co, cross_sum, {H{1'b0}}};
            end

            rca_add #(.N(2*W)) u_final (
                .x(outer), .y(cross_sh), .cin(1'b0),
                .sum(p), .cout(spill)
            );
        end
    endgenerate

endmodule

// File: rtl/logic_unit.sv
// Module logic_unit
// Bitwise AND, OR, and inversion of the first operand, computed side by side.
// Assumes equal operand widths. The inversion reads only a.
module logic_unit #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] f_and,
    output logic [W-1:0] f_or,
    output logic [W-1:0] f_inv
);

    // Forms the three bitwise results at once.
    always_comb begin
        f_and = a & b;
        f_or  = a | b;
        f_inv = ~a;
    end

endmodule

// File: rtl/alu_vc_mux.sv
// Module alu_vc_mux
// Top of the combinational ALU. The adder, the vertical-and-crosswise
// multiplier and the logic unit all see the operands at once. The select
// code is decoded into ranges and drives one output multiplexer.
// Assumes unsigned operands. Narrow results are zero-extended.
module alu_vc_mux
    import alu_vc_pkg::*;
#(
    parameter int DW = OPND_W
) (
    input  logic [DW-1:0]    opnd_a,
    input  logic [DW-1:0]    opnd_b,
    input  logic [SEL_W-1:0] sel,
    output logic [2*DW-1:0]  result
);

    localparam int RW  = 2 * DW;
    localparam int SUM_PAD = RW - DW - 1;
    localparam int LOG_PAD = RW - DW;

    logic [DW-1:0] add_sum;
    logic          add_co;
    logic [RW-1:0] mul_p;
    logic [DW-1:0] lg_and;
    logic [DW-1:0] lg_or;
    logic [DW-1:0] lg_inv;
    op_class_e     op_cls;

    rca_add #(.N(DW)) u_add (
        .x(opnd_a), .y(opnd_b), .cin(1'b0),
        .sum(add_sum), .cout(add_co)
    );

    vc_mul #(.W(DW)) u_mul (.a(opnd_a), .b(opnd_b), .p(mul_p));

    logic_unit #(.W(DW)) u_logic (
        .a(opnd_a), .b(opnd_b),
        .f_and(lg_and), .f_or(lg_or), .f_inv(lg_inv)
    );

    // Turns the select code into its class of operation.
    assign op_cls = decode_sel(sel);

    // Output multiplexer: passes the result of the chosen class.
    always_comb begin
        case (op_cls)
            CLS_SUM:  result = {{SUM_PAD{1'b0}}, add_co, add_sum};
            CLS_PROD: result = mul_p;
            CLS_AND:  result = {{LOG_PAD{1'b0}}, lg_and};
            CLS_OR:   result = {{LOG_PAD{1'b0}}, lg_or};
            default:  result = {{LOG_PAD{1'b0}}, lg_inv};
        endcase
    end

endmodule

// File: rtl/alu_vc_mux_chk.sv
// Module alu_vc_mux_chk
// Checker bound to alu_vc_mux. It tests properties of each class of result
// at the ports, without rebuilding the datapath. Immediate assertions only,
// since the block has no clock.
module alu_vc_mux_chk #(
    parameter int DW = 4
) (
    input logic [DW-1:0]   opnd_a,
    input logic [DW-1:0]   opnd_b,
    input logic [3:0]      sel,
    input logic [2*DW-1:0] result
);

    localparam int RW = 2 * DW;

    logic [RW-1:0] a_ext;
    logic [RW-1:0] b_ext;

    // Widens the operands for comparisons against the result.
    always_comb begin
        a_ext = {{(RW-DW){1'b0}}, opnd_a};
        b_ext = {{(RW-DW){1'b0}}, opnd_b};
    end

    // Checks each select range against properties of its operation.
    always_comb begin
        if (sel <= 4'd3) begin
            // R1: the sum covers each operand and needs at most DW+1 bits
            assert_sum_bounds_R1: assert ((result >= a_ext) && (result >= b_ext)
                                          && ((result >> (DW + 1)) == '0))
                else $error("sum range property broken");
        end else if (sel <= 4'd12) begin
            // R2: a zero factor gives zero, and a unit factor passes a through
            assert_prod_zero_R2: assert (!((opnd_a == '0) || (opnd_b == '0)) || (result == '0))
                else $error("product of zero is not zero");
            assert_prod_unit_R2: assert ((opnd_b != 1) || (result == a_ext))
                else $error("product by one differs from operand");
        end else if (sel == 4'd13) begin
            // R3: AND result has no bit outside either operand
            assert_and_subset_R3: assert (((result & ~a_ext) == '0) && ((result & ~b_ext) == '0))
                else $error("AND result exceeds an operand");
        end else if (sel == 4'd14) begin
            // R4: OR result contains both operands and nothing above them
            assert_or_cover_R4: assert (((a_ext & ~result) == '0) && ((b_ext & ~result) == '0)
                                        && ((result >> DW) == '0))
                else $error("OR result misses an operand bit");
        end else begin
            // R5: inversion is disjoint from a and completes it to all ones
            assert_inv_complement_R5: assert (((result[DW-1:0] & opnd_a) == '0)
                                              && ((result[DW-1:0] | opnd_a) == '1)
                                              && ((result >> DW) == '0))
                else $error("inversion is not the complement of a");
        end
    end

endmodule

// Module vc_mul_chk
// Checker bound to every multiplier level: the final carry stays clear.
module vc_mul_chk (
    input logic spill
);

    // Watches the carry out of the last adder of the multiplier.
    always_comb begin
        // R7: the product fits in 2W bits, so the final carry stays clear
        assert_no_overflow_R7: assert (spill == 1'b0)
            else $error("multiplier final carry set");
    end

endmodule

bind alu_vc_mux alu_vc_mux_chk #(.DW(DW)) u_alu_chk (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sel(sel), .result(result)
);

bind vc_mul vc_mul_chk u_mul_chk (.spill(spill));

// File: tb/alu_vc_mux_bench.sv
// Directed bench for alu_vc_mux. Inputs change at the falling edge and the
// result is sampled 2 ns later, in the same low clock phase.
module alu_vc_mux_bench;

    localparam int WATCHDOG_CYCLES = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opnd_a = '0;
    logic [3:0] opnd_b = '0;
    logic [3:0] sel = '0;
    logic [7:0] result;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    alu_vc_mux u_alu_vc_mux (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sel(sel), .result(result)
    );

    always #5 clk = ~clk;

    // Expected value, taken from the requirements.
    function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b,
                                         input logic [3:0] s);
        if (s <= 4'd3)       return 8'(a) + 8'(b);
        else if (s <= 4'd12) return 8'(a) * 8'(b);
        else if (s == 4'd13) return {4'h0, a & b};
        else if (s == 4'd14) return {4'h0, a | b};
        else                 return {4'h0, ~a};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d sel=%0d actual=%h expected=%h",
                     req, opnd_a, opnd_b, sel, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s);
        @(negedge clk);
        opnd_a = a;
        opnd_b = b;
        sel    = s;
        #2;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        #2;
        check("R1 idle inputs", result, 8'h00);
        @(posedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_sum_codes;
        for (int s = 0; s <= 3; s++) begin
            apply(4'd9, 4'd5, 4'(s));
            check("R1 sum 9+5", result, 8'd14);
        end
        apply(4'd15, 4'd15, 4'd2);
        check("R7 sum 15+15", result, 8'h1E);
    endtask

    task automatic t_prod_codes;
        for (int s = 4; s <= 12; s++) begin
            apply(4'd7, 4'd6, 4'(s));
            check("R2 product 7*6", result, 8'd42);
        end
        apply(4'd15, 4'd15, 4'd8);
        check("R7 product 15*15", result, 8'hE1);
        apply(4'd0, 4'd13, 4'd4);
        check("R2 product by zero", result, 8'h00);
    endtask

    task automatic t_logic_codes;
        apply(4'b1100, 4'b1010, 4'd13);
        check("R3 AND", result, 8'h08);
        apply(4'b1100, 4'b1010, 4'd14);
        check("R4 OR", result, 8'h0E);
        apply(4'b1100, 4'b1010, 4'd15);
        check("R5 invert a", result, 8'h03);
    endtask

    task automatic t_inv_ignores_b;
        for (int b = 0; b < 16; b++) begin
            apply(4'b0110, 4'(b), 4'd15);
            check("R5 b has no effect", result, 8'h09);
        end
    endtask

    task automatic t_select_only;
        @(negedge clk);
        opnd_a = 4'd11;
        opnd_b = 4'd3;
        sel    = 4'd0;
        #1;
        check("R6 sum without edge", result, 8'd14);
        sel = 4'd5;
        #1;
        check("R6 product without edge", result, 8'd33);
        sel = 4'd14;
        #1;
        check("R6 OR without edge", result, 8'h0B);
    endtask

    task automatic t_full_sweep;
        for (int s = 0; s < 16; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    apply(4'(a), 4'(b), 4'(s));
                    if (s <= 3)       check("R1 sweep", result, model(4'(a), 4'(b), 4'(s)));
                    else if (s <= 12) check("R2 sweep", result, model(4'(a), 4'(b), 4'(s)));
                    else if (s == 13) check("R3 sweep", result, model(4'(a), 4'(b), 4'(s)));
                    else if (s == 14) check("R4 sweep", result, model(4'(a), 4'(b), 4'(s)));
                    else              check("R5 sweep", result, model(4'(a), 4'(b), 4'(s)));
                end
    endtask

    initial begin
        t_reset_state();
        t_sum_codes();
        t_prod_codes();
        t_logic_codes();
        t_inv_ignores_b();
        t_select_only();
        t_full_sweep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule